// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command interpreter of an 8-bit parallel NOR flash. It watches host write cycles, each with a 19-bit address and a data byte, and matches them against the multi-cycle unlock sequences that guard every destructive operation. A matched sequence produces a single-cycle start strobe to an operation engine: program, chip erase, sector erase, suspend or resume. The strobe carries the latched address and data of the final write.

The block also chooses what a host read returns: array data, autoselect identification codes, or operation status. It follows the engine through busy, suspended and failed states using a done pulse and a failure pulse. While an operation runs, only a narrow set of writes is honoured. Everything else is dropped. A write that breaks a sequence sends the decoder back to array-read mode. The memory array, the engine's timing and the high-voltage identification path are outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and in the cycle after any cycle with `lockout_i` high, `read_mode_o` is 0 (array), `busy_o`, `suspended_o` and `failed_o` are 0, no strobe is raised, and any partly entered sequence is discarded.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then data D at address A raise `pgm_start_o` for exactly one cycle, in the cycle after the fourth write, with `op_addr_o`=A and `op_data_o`=D. `busy_o` is 1 and `read_mode_o` is 2 (status) until `eng_done_i`.
- R3: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `chip_erase_start_o` for one cycle and set `busy_o`.
- R4: The same five setup writes followed by 30h at any address raise `sector_erase_start_o` for one cycle. Bits 18:16 of that address select one of eight sectors and appear on `op_addr_o`.
- R5: Unlock addresses are compared on bits 10:0 only. A write with a wrong address, a wrong data byte or an unexpected step drops the partial sequence, so the write that would have completed it starts nothing.
- R6: Write 90h as the third step while idle to enter autoselect (`read_mode_o`=1). `id_data_o` is then decoded from `rd_addr_i[7:0]`. Offset 00h returns 1Ch when `rd_addr_i[8]` is 1 and 7Fh when it is 0. Offset 01h returns 4Fh. Offset 02h returns 01h if `prot_i[rd_addr_i[18:16]]` is set and 00h if it is clear. Any other offset returns 00h.
- R7: F0h written at any address, at any step other than the program-data step, cancels a sequence and leaves autoselect. In autoselect every other write is ignored.
- R8: While a program or chip erase is running, every write is ignored, including suspend (B0h) and reset (F0h).
- R9: B0h at any address during a sector erase raises `suspend_o` and sets `suspended_o`. While suspended, reads inside the erasing sector report status (mode 2) and reads elsewhere report array (mode 0). During a sector erase all other writes are ignored.
- R10: 30h written while suspended with no sequence pending raises `resume_o` and returns to busy erasing. Further 30h writes are ignored, and a new B0h is accepted again.
- R11: While suspended, the autoselect and erase setups are refused, but a program sequence is accepted. Its `eng_done_i` returns the block to the suspended state.
- R12: Engine pulses are applied before a write in the same cycle. A write is decoded against the state left after `eng_done_i` or `eng_fail_i`.
- R13: `eng_fail_i` during an operation sets `failed_o` and status mode. Only F0h clears it; all other writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lockout_i | input | 1 | Low-supply lockout, forces array read |
| wr_en_i | input | 1 | Host write cycle valid |
| wr_addr_i | input | 19 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 19 | Current read address |
| prot_i | input | 8 | Per-sector protection flags |
| eng_done_i | input | 1 | Engine finished the current operation |
| eng_fail_i | input | 1 | Engine exceeded its time limit |
| pgm_start_o | output | 1 | Program start strobe |
| chip_erase_start_o | output | 1 | Chip erase start strobe |
| sector_erase_start_o | output | 1 | Sector erase start strobe |
| suspend_o | output | 1 | Erase suspend strobe |
| resume_o | output | 1 | Erase resume strobe |
| op_addr_o | output | 19 | Address latched with the last strobe |
| op_data_o | output | 8 | Data latched with the last strobe |
| read_mode_o | output | 2 | 0 array, 1 autoselect, 2 status |
| id_data_o | output | 8 | Autoselect code for rd_addr_i |
| busy_o | output | 1 | Operation running |
| suspended_o | output | 1 | Sector erase suspended |
| failed_o | output | 1 | Operation failed, awaiting reset |

## Verification
The collision that matters is between an engine completion and a host write in the same cycle. The clearest case is `eng_done_i` of a sector erase arriving together with a B0h suspend write. The bench raises both inputs on one clock edge. Because completion is applied first, the write must be decoded as an idle-state write: no suspend strobe, with `busy_o` and `suspended_o` both low afterwards. A full program sequence issued right after must still start normally.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int unsigned CMP_W = 11;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PDATA, SQ_ERS1, SQ_ERS2, SQ_ERS3
  } seq_e;

  typedef enum logic [2:0] {
    OP_IDLE, OP_PROG, OP_CERASE, OP_SERASE, OP_SUSP, OP_SUSP_PROG, OP_FAIL
  } op_e;

  typedef enum logic [2:0] {
    CM_NONE, CM_PGM, CM_CERASE, CM_SERASE, CM_SUSPEND, CM_RESUME, CM_AUTOSEL, CM_RESET
  } cmd_e;

  localparam logic [1:0] RM_ARRAY  = 2'd0;
  localparam logic [1:0] RM_IDENT  = 2'd1;
  localparam logic [1:0] RM_STATUS = 2'd2;

  localparam logic [CMP_W-1:0] UNL_ADDR1 = 11'h555;
  localparam logic [CMP_W-1:0] UNL_ADDR2 = 11'h2AA;

  localparam logic [7:0] CD_UNL1    = 8'hAA;
  localparam logic [7:0] CD_UNL2    = 8'h55;
  localparam logic [7:0] CD_PGM     = 8'hA0;
  localparam logic [7:0] CD_IDENT   = 8'h90;
  localparam logic [7:0] CD_ERASE   = 8'h80;
  localparam logic [7:0] CD_CHIP    = 8'h10;
  localparam logic [7:0] CD_SECT    = 8'h30;
  localparam logic [7:0] CD_SUSPEND = 8'hB0;
  localparam logic [7:0] CD_RESET   = 8'hF0;

  function automatic logic op_busy(op_e op);
    return (op == OP_PROG) || (op == OP_CERASE) || (op == OP_SERASE) || (op == OP_SUSP_PROG);
  endfunction

endpackage

// File: rtl/fcs_seq_decode.sv
module fcs_seq_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  op_e               op_i,
  input  logic              ident_i,
  output cmd_e              cmd_o
);

  seq_e seq_q, seq_d;
  cmd_e cmd_d;
  logic a1_hit, a2_hit;

  assign a1_hit = (wr_addr_i[CMP_W-1:0] == UNL_ADDR1);
  assign a2_hit = (wr_addr_i[CMP_W-1:0] == UNL_ADDR2);

  always_comb begin
    cmd_d = CM_NONE;
    seq_d = seq_q;
    if (wr_en_i) begin
      seq_d = SQ_IDLE;
      case (op_i)
        OP_FAIL:   if (wr_data_i == CD_RESET) cmd_d = CM_RESET;
        OP_SERASE: if (wr_data_i == CD_SUSPEND) cmd_d = CM_SUSPEND;
        OP_IDLE, OP_SUSP: begin
          if (ident_i) begin
            if (wr_data_i == CD_RESET) cmd_d = CM_RESET;
          end else if (seq_q != SQ_PDATA && wr_data_i == CD_RESET) begin
            cmd_d = CM_RESET;
          end else if (seq_q == SQ_IDLE && op_i == OP_SUSP && wr_data_i == CD_SECT) begin
            cmd_d = CM_RESUME;
          end else begin
            case (seq_q)
              SQ_IDLE: if (a1_hit && wr_data_i == CD_UNL1) seq_d = SQ_UNL1;
              SQ_UNL1: if (a2_hit && wr_data_i == CD_UNL2) seq_d = SQ_UNL2;
              SQ_UNL2: if (a1_hit) begin
                if (wr_data_i == CD_PGM) seq_d = SQ_PDATA;
                else if (wr_data_i == CD_IDENT && op_i == OP_IDLE) cmd_d = CM_AUTOSEL;
                else if (wr_data_i == CD_ERASE && op_i == OP_IDLE) seq_d = SQ_ERS1;
              end
              SQ_PDATA: cmd_d = CM_PGM;
              SQ_ERS1: if (a1_hit && wr_data_i == CD_UNL1) seq_d = SQ_ERS2;
              SQ_ERS2: if (a2_hit && wr_data_i == CD_UNL2) seq_d = SQ_ERS3;
              SQ_ERS3: begin
                if (a1_hit && wr_data_i == CD_CHIP) cmd_d = CM_CERASE;
                else if (wr_data_i == CD_SECT) cmd_d = CM_SERASE;
              end
              default: ;
            endcase
          end
        end
        default: ;  // program or chip erase running: ignore
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seq_q <= SQ_IDLE;
    else if (clr_i)  seq_q <= SQ_IDLE;
    else             seq_q <= seq_d;
  end

  assign cmd_o = clr_i ? CM_NONE : cmd_d;

endmodule

// File: rtl/fcs_op_state.sv
module fcs_op_state
  import flash_cmd_pkg::*;
#(
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              done_i,
  input  logic              fail_i,
  input  cmd_e              cmd_i,
  input  logic [SECT_W-1:0] sect_i,
  output op_e               op_o,
  output op_e               op_eff_o,
  output logic              ident_o,
  output logic [SECT_W-1:0] susp_sect_o
);

  op_e               op_q, op_eff, op_d;
  logic              ident_q, ident_d;
  logic [SECT_W-1:0] sect_q, sect_d;

  // engine events land before the write of the same cycle
  always_comb begin
    op_eff = op_q;
    if (op_busy(op_q)) begin
      if (fail_i)      op_eff = OP_FAIL;
      else if (done_i) op_eff = (op_q == OP_SUSP_PROG) ? OP_SUSP : OP_IDLE;
    end
  end

  always_comb begin
    op_d    = op_eff;
    ident_d = ident_q;
    sect_d  = sect_q;
    case (cmd_i)
      CM_PGM:     op_d = (op_eff == OP_SUSP) ? OP_SUSP_PROG : OP_PROG;
      CM_CERASE:  op_d = OP_CERASE;
      CM_SERASE:  begin op_d = OP_SERASE; sect_d = sect_i; end
      CM_SUSPEND: op_d = OP_SUSP;
      CM_RESUME:  op_d = OP_SERASE;
      CM_AUTOSEL: ident_d = 1'b1;
      CM_RESET: begin
        ident_d = 1'b0;
        if (op_eff == OP_FAIL) op_d = OP_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      ident_q <= 1'b0;
      sect_q  <= '0;
    end else if (clr_i) begin
      op_q    <= OP_IDLE;
      ident_q <= 1'b0;
    end else begin
      op_q    <= op_d;
      ident_q <= ident_d;
      sect_q  <= sect_d;
    end
  end

  assign op_o        = op_q;
  assign op_eff_o    = op_eff;
  assign ident_o     = ident_q;
  assign susp_sect_o = sect_q;

endmodule

// File: rtl/fcs_ident.sv
module fcs_ident #(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned SECT_W  = 3,
  parameter logic [7:0]  MFR_ID  = 8'h1C,
  parameter logic [7:0]  FILL_ID = 8'h7F,
  parameter logic [7:0]  DEV_ID  = 8'h4F
) (
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [(1<<SECT_W)-1:0] prot_i,
  output logic [7:0]             id_o
);

  logic [SECT_W-1:0] sect;
  assign sect = rd_addr_i[ADDR_W-1 -: SECT_W];

  always_comb begin
    case (rd_addr_i[7:0])
      8'h00:   id_o = rd_addr_i[8] ? MFR_ID : FILL_ID;
      8'h01:   id_o = DEV_ID;
      8'h02:   id_o = {7'd0, prot_i[sect]};
      default: id_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned SECT_W = 3,
  localparam int unsigned NSECT = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lockout_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [NSECT-1:0]  prot_i,
  input  logic              eng_done_i,
  input  logic              eng_fail_i,
  output logic              pgm_start_o,
  output logic              chip_erase_start_o,
  output logic              sector_erase_start_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic [1:0]        read_mode_o,
  output logic [7:0]        id_data_o,
  output logic              busy_o,
  output logic              suspended_o,
  output logic              failed_o
);

  cmd_e              cmd;
  op_e               op_q, op_eff;
  logic              ident;
  logic [SECT_W-1:0] susp_sect;

  fcs_seq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (lockout_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .op_i      (op_eff),
    .ident_i   (ident),
    .cmd_o     (cmd)
  );

  fcs_op_state #(.SECT_W(SECT_W)) u_op (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (lockout_i),
    .done_i      (eng_done_i),
    .fail_i      (eng_fail_i),
    .cmd_i       (cmd),
    .sect_i      (wr_addr_i[ADDR_W-1 -: SECT_W]),
    .op_o        (op_q),
    .op_eff_o    (op_eff),
    .ident_o     (ident),
    .susp_sect_o (susp_sect)
  );

  fcs_ident #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_id (
    .rd_addr_i (rd_addr_i),
    .prot_i    (prot_i),
    .id_o      (id_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_start_o          <= 1'b0;
      chip_erase_start_o   <= 1'b0;
      sector_erase_start_o <= 1'b0;
      suspend_o            <= 1'b0;
      resume_o             <= 1'b0;
      op_addr_o            <= '0;
      op_data_o            <= '0;
    end else begin
      pgm_start_o          <= (cmd == CM_PGM);
      chip_erase_start_o   <= (cmd == CM_CERASE);
      sector_erase_start_o <= (cmd == CM_SERASE);
      suspend_o            <= (cmd == CM_SUSPEND);
      resume_o             <= (cmd == CM_RESUME);
      if (cmd inside {CM_PGM, CM_CERASE, CM_SERASE, CM_SUSPEND, CM_RESUME}) begin
        op_addr_o <= wr_addr_i;
        op_data_o <= wr_data_i;
      end
    end
  end

  always_comb begin
    case (op_q)
      OP_PROG, OP_CERASE, OP_SERASE, OP_SUSP_PROG, OP_FAIL: read_mode_o = RM_STATUS;
      OP_SUSP: read_mode_o = (rd_addr_i[ADDR_W-1 -: SECT_W] == susp_sect) ? RM_STATUS : RM_ARRAY;
      default: read_mode_o = ident ? RM_IDENT : RM_ARRAY;
    endcase
  end

  assign busy_o      = op_busy(op_q);
  assign suspended_o = (op_q == OP_SUSP) || (op_q == OP_SUSP_PROG);
  assign failed_o    = (op_q == OP_FAIL);

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lockout_i,
  input logic       pgm_start_o,
  input logic       chip_erase_start_o,
  input logic       sector_erase_start_o,
  input logic       suspend_o,
  input logic       resume_o,
  input logic [1:0] read_mode_o,
  input logic       busy_o,
  input logic       suspended_o,
  input logic       failed_o
);

  logic [4:0] strobes;
  assign strobes = {pgm_start_o, chip_erase_start_o, sector_erase_start_o, suspend_o, resume_o};

  assert_strobe_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobes));

  assert_pgm_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_start_o |=> !pgm_start_o);

  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_start_o || chip_erase_start_o || sector_erase_start_o) |-> busy_o);

  assert_suspend_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> (suspended_o && !busy_o));

  assert_resume_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (busy_o && !suspended_o));

  assert_lockout_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> (read_mode_o == 2'd0 && !busy_o && strobes == 5'd0));

  assert_fail_status_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed_o |-> (read_mode_o == 2'd2 && !busy_o));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk_i                (clk_i),
  .rst_ni               (rst_ni),
  .lockout_i            (lockout_i),
  .pgm_start_o          (pgm_start_o),
  .chip_erase_start_o   (chip_erase_start_o),
  .sector_erase_start_o (sector_erase_start_o),
  .suspend_o            (suspend_o),
  .resume_o             (resume_o),
  .read_mode_o          (read_mode_o),
  .busy_o               (busy_o),
  .suspended_o          (suspended_o),
  .failed_o             (failed_o)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lockout = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [18:0] rd_addr = '0;
  logic [7:0]  prot = 8'b0010_0100;
  logic        eng_done = 1'b0;
  logic        eng_fail = 1'b0;
  logic        pgm_s, cer_s, ser_s, sus_s, res_s;
  logic [18:0] op_addr;
  logic [7:0]  op_data, id_data;
  logic [1:0]  read_mode;
  logic        busy, suspended, failed;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [4:0] last_stb;
  logic [18:0] last_addr;
  logic [7:0]  last_data;

  always #10 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .lockout_i(lockout),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .prot_i(prot),
    .eng_done_i(eng_done), .eng_fail_i(eng_fail),
    .pgm_start_o(pgm_s), .chip_erase_start_o(cer_s), .sector_erase_start_o(ser_s),
    .suspend_o(sus_s), .resume_o(res_s), .op_addr_o(op_addr), .op_data_o(op_data),
    .read_mode_o(read_mode), .id_data_o(id_data),
    .busy_o(busy), .suspended_o(suspended), .failed_o(failed)
  );

  function automatic logic [7:0] exp_id(logic [18:0] a, logic [7:0] p);
    case (a[7:0])
      8'h00:   return a[8] ? 8'h1C : 8'h7F;
      8'h01:   return 8'h4F;
      8'h02:   return {7'd0, p[a[18:16]]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called just after a negedge; strobes sampled at the next negedge
  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_stb  = {pgm_s, cer_s, ser_s, sus_s, res_s};
    last_addr = op_addr;
    last_data = op_data;
  endtask

  task automatic unlock();
    wr(19'h555, 8'hAA);
    wr(19'h2AA, 8'h55);
  endtask

  task automatic erase_setup();
    unlock(); wr(19'h555, 8'h80); unlock();
  endtask

  task automatic engine_done();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic do_program(input logic [18:0] a, input logic [7:0] d);
    unlock(); wr(19'h555, 8'hA0); wr(a, d);
  endtask

  initial begin
    #4ms;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mode after reset", read_mode, 0);
    chk("R1", "busy/susp/fail after reset", {busy, suspended, failed}, 0);

    // R2 program
    do_program(19'h12345, 8'h5A);
    chk("R2", "program strobe", last_stb, 5'b10000);
    chk("R2", "program addr", last_addr, 19'h12345);
    chk("R2", "program data", last_data, 8'h5A);
    chk("R2", "busy and status", {busy, read_mode}, {1'b1, 2'd2});
    @(negedge clk);
    chk("R2", "strobe is one pulse", pgm_s, 0);
    // R8 suspend ignored while programming
    wr(19'h0, 8'hB0);
    chk("R8", "suspend ignored in program", last_stb, 0);
    engine_done();
    chk("R2", "idle after done", {busy, read_mode}, 0);

    // R5 upper address bits ignored
    wr(19'h4D555, 8'hAA); wr(19'h3AAAA, 8'h55); wr(19'h7F555, 8'hA0); wr(19'h00777, 8'hC3);
    chk("R5", "low 11 bits compare", last_stb, 5'b10000);
    engine_done();

    // R5 bad steps
    unlock(); wr(19'h555, 8'h91); wr(19'h100, 8'h33);
    chk("R5", "wrong command byte", last_stb, 0);
    wr(19'h555, 8'hAA); wr(19'h2AB, 8'h55); wr(19'h555, 8'hA0); wr(19'h100, 8'h33);
    chk("R5", "wrong unlock address", last_stb, 0);
    chk("R5", "not busy", busy, 0);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (d inside {8'hA0, 8'h80, 8'h90, 8'hF0}) d = 8'h12;
      unlock(); wr(19'h555, d); wr(19'h100, 8'h33);
      chk("R5", "random wrong third byte", {last_stb, busy}, 0);
    end

    // R3 chip erase, R8 writes ignored
    erase_setup(); wr(19'h555, 8'h10);
    chk("R3", "chip erase strobe", last_stb, 5'b01000);
    chk("R3", "busy", busy, 1);
    wr(19'h0, 8'hB0);
    chk("R8", "suspend ignored in chip erase", last_stb, 0);
    wr(19'h0, 8'hF0);
    chk("R8", "reset ignored in chip erase", busy, 1);
    for (int i = 0; i < 30; i++) begin
      wr(19'($urandom), 8'($urandom));
      chk("R8", "random write ignored", {last_stb, busy}, 6'b000001);
    end
    engine_done();

    // R4 sector erase
    erase_setup(); wr(19'h53210, 8'h30);
    chk("R4", "sector erase strobe", last_stb, 5'b00100);
    chk("R4", "sector address", last_addr[18:16], 3'd5);
    wr(19'h555, 8'hAA);
    chk("R9", "other write ignored in sector erase", last_stb, 0);
    wr(19'h01234, 8'hB0);
    chk("R9", "suspend strobe", last_stb, 5'b00010);
    chk("R9", "suspended flags", {busy, suspended}, 2'b01);
    rd_addr = 19'h50000; #1;
    chk("R9", "status in erasing sector", read_mode, 2);
    rd_addr = 19'h20000; #1;
    chk("R9", "array elsewhere", read_mode, 0);

    // R11 restrictions while suspended
    unlock(); wr(19'h555, 8'h90);
    chk("R11", "no autoselect in suspend", read_mode, 0);
    erase_setup(); wr(19'h555, 8'h10);
    chk("R11", "no chip erase in suspend", last_stb, 0);
    do_program(19'h21000, 8'h44);
    chk("R11", "program in suspend", last_stb, 5'b10000);
    chk("R11", "suspended program flags", {busy, suspended}, 2'b11);
    wr(19'h0, 8'h30);
    chk("R11", "resume ignored while programming", last_stb, 0);
    engine_done();
    chk("R11", "back to suspended", {busy, suspended}, 2'b01);

    // R10 resume
    wr(19'h0, 8'h30);
    chk("R10", "resume strobe", last_stb, 5'b00001);
    chk("R10", "erasing again", {busy, suspended}, 2'b10);
    wr(19'h0, 8'h30);
    chk("R10", "second resume ignored", last_stb, 0);
    wr(19'h0, 8'hB0);
    chk("R10", "suspend after resume", last_stb, 5'b00010);
    wr(19'h0, 8'h30);
    engine_done();
    chk("R10", "idle after erase done", {busy, suspended}, 0);

    // R6 autoselect
    unlock(); wr(19'h555, 8'h90);
    rd_addr = 19'h0; #1;
    chk("R6", "autoselect mode", read_mode, 1);
    rd_addr = 19'h00100; #1; chk("R6", "manufacturer", id_data, 8'h1C);
    rd_addr = 19'h00000; #1; chk("R6", "filler", id_data, 8'h7F);
    rd_addr = 19'h00001; #1; chk("R6", "device", id_data, 8'h4F);
    rd_addr = 19'h20002; #1; chk("R6", "protected sector", id_data, 8'h01);
    rd_addr = 19'h30002; #1; chk("R6", "unprotected sector", id_data, 8'h00);
    for (int i = 0; i < 40; i++) begin
      logic [18:0] a;
      a = {3'($urandom), 7'd0, 1'($urandom), 6'd0, 2'($urandom)};
      rd_addr = a; #1;
      chk("R6", "random id read", id_data, exp_id(a, prot));
    end
    @(negedge clk);
    // R7
    do_program(19'h00200, 8'h11);
    chk("R7", "program ignored in autoselect", last_stb, 0);
    chk("R7", "still autoselect", read_mode, 1);
    wr(19'h00777, 8'hF0);
    chk("R7", "reset leaves autoselect", read_mode, 0);
    unlock(); wr(19'h0, 8'hF0); wr(19'h555, 8'hA0); wr(19'h100, 8'h22);
    chk("R7", "reset cancels sequence", last_stb, 0);

    // R13 failure
    do_program(19'h00300, 8'h00);
    eng_fail = 1'b1; @(negedge clk); eng_fail = 1'b0;
    chk("R13", "failed status", {failed, busy, read_mode}, {1'b1, 1'b0, 2'd2});
    do_program(19'h00300, 8'h01);
    chk("R13", "writes ignored when failed", {last_stb, failed}, 6'b000001);
    wr(19'h0, 8'hF0);
    chk("R13", "reset clears failure", {failed, read_mode}, 0);

    // R12 done and suspend write collide
    erase_setup(); wr(19'h10000, 8'h30);
    eng_done = 1'b1;
    wr(19'h0, 8'hB0);
    eng_done = 1'b0;
    chk("R12", "suspend dropped on completion", last_stb, 0);
    chk("R12", "idle after collision", {busy, suspended}, 0);
    do_program(19'h00400, 8'h77);
    chk("R12", "program after collision", last_stb, 5'b10000);
    engine_done();

    // R1 lockout discards partial sequence
    unlock(); wr(19'h555, 8'hA0);
    lockout = 1'b1; @(negedge clk); lockout = 1'b0;
    wr(19'h00500, 8'h66);
    chk("R1", "lockout drops sequence", last_stb, 0);
    unlock(); wr(19'h555, 8'h90);
    lockout = 1'b1; @(negedge clk); lockout = 1'b0;
    chk("R1", "lockout leaves autoselect", read_mode, 0);
    erase_setup(); wr(19'h555, 8'h10);
    lockout = 1'b1; @(negedge clk); lockout = 1'b0;
    chk("R1", "lockout clears busy", busy, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule